// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Shadow Register Window

This core keeps calendar time as packed BCD counters: seconds, minutes, hours (24-hour form), day of week, date, month, year and century. A one-cycle pulse on `tick_i`, expected once per second, advances the counters. Software never reads or writes the live counters. It sees a byte-wide window of shadow copies. While the clock runs freely, the shadows track the counters.

The control byte has two freeze bits. Setting the read-freeze bit holds a coherent snapshot while the counters keep running. Setting the write-freeze bit also holds the snapshot, and it opens the time bytes for loading. When the write-freeze bit is then cleared, every time byte moves into the counters in a single cycle. A stop flag in the seconds byte halts the counters themselves.

Read data is registered. The byte for the offset presented in cycle N appears on `rdata_o` after the clock edge that ends cycle N. The shadows trail the counters by one cycle.

Top module: `rtc_shadow_top`

## Requirements
- R1: The live counters advance on every `tick_i` (unless stopped), whatever the freeze bits hold. After a read freeze is released and a tick arrives, the window shows a time that includes every tick seen during the freeze.
- R2: While control bit 6 (read-freeze) is 1 and bit 7 is 0, every shadow byte keeps its value across any number of ticks.
- R3: The snapshot taken by a control write that sets a freeze bit holds the counter value present in the cycle of that write. A tick in the same cycle is not part of the snapshot.
- R4: After read-freeze is cleared (with write-freeze 0), the shadows keep the frozen value until the next tick. From then on they follow the counters again.
- R5: Time bytes can be written only while control bit 7 (write-freeze) is 1, and they can be read back at once. A write to a time byte while bit 7 is 0 leaves that byte unchanged.
- R6: A control write that turns bit 7 from 1 to 0 loads all time bytes, including the stop flag, into the counters in one cycle. A tick in that same cycle is dropped.
- R7: Rollover cascades as follows:
  - seconds 59 goes to 00, and minutes 59 goes to 00;
  - hours 23 goes to 00 and advances both the day of week (7 wraps to 1) and the date;
  - the date wraps to 01 after the last day of the month (30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when the year is a multiple of 4; 31 otherwise);
  - month 12 goes to 01 and carries into the year, and year 99 goes to 00 and carries into the century.
- R8: After reset the control byte reads 0x00. Time reads 00:00:00, day 1, date 01, month 01, year 00, century 00.
- R9: When bit 7 of the seconds byte (the stop flag) is 1 in the counters, ticks do not change any counter.
- R10: The window offsets are as follows:
  - 0x1 century, 0x8 control, 0x9 seconds (bit 7 stop), 0xA minutes;
  - 0xB hours, 0xC day of week, 0xD date, 0xE month, 0xF year.
  - Undefined bits read 0. These are control bits 5..0, minutes bit 7, hours bits 7..6, day bits 7..3, date bits 7..6 and month bits 7..5.
  - Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Write strobe for the register window |
| addr_i | input | ADDR_W | Window offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's offset |

## Verification
The checkers assume that every value committed into the counters is legal packed BCD within its range. The range property relies on that. They also assume that `tick_i` is a single-cycle pulse. The bench only loads legal times, with the date within the month's length. It raises the tick for one cycle at a time, and it places ticks in the same cycle as control writes only in the scenarios that test those collisions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
    logic [7:0] cent;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
                                      hour: 6'h00, dow: 3'd1, date: 6'h01,
                                      mon: 5'h01, year: 8'h00, cent: 8'h00};

  // Next packed-BCD value, wrapping from last to first.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    if (v == last)
      return first;
    else if (v[3:0] == 4'h9)
      return {v[7:4] + 4'h1, 4'h0};
    else
      return v + 8'h01;
  endfunction

  // Last date of a month; leap when the BCD year is a multiple of four.
  function automatic logic [5:0] month_last(input logic [4:0] mon,
                                            input logic       tens_odd,
                                            input logic [1:0] ones_lo);
    logic leap;
    leap = tens_odd ? (ones_lo == 2'b10) : (ones_lo == 2'b00);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t live_o
);

  rtc_time_t cur, nxt;
  logic      adv;
  logic      c_sec, c_min, c_hour, c_date, c_mon, c_year;
  logic [5:0] mlast;

  assign cur = live_o;
  assign adv = tick_i && !cur.stop;

  always_comb begin
    mlast  = month_last(cur.mon, cur.year[4], cur.year[1:0]);
    c_sec  = adv    && (cur.sec  == 7'h59);
    c_min  = c_sec  && (cur.min  == 7'h59);
    c_hour = c_min  && (cur.hour == 6'h23);
    c_date = c_hour && (cur.date == mlast);
    c_mon  = c_date && (cur.mon  == 5'h12);
    c_year = c_mon  && (cur.year == 8'h99);
    nxt = cur;
    if (adv)    nxt.sec  = 7'(bcd_inc({1'b0, cur.sec}, 8'h59, 8'h00));
    if (c_sec)  nxt.min  = 7'(bcd_inc({1'b0, cur.min}, 8'h59, 8'h00));
    if (c_min)  nxt.hour = 6'(bcd_inc({2'b0, cur.hour}, 8'h23, 8'h00));
    if (c_hour) begin
      nxt.dow  = 3'(bcd_inc({5'b0, cur.dow}, 8'h07, 8'h01));
      nxt.date = 6'(bcd_inc({2'b0, cur.date}, {2'b0, mlast}, 8'h01));
    end
    if (c_date) nxt.mon  = 5'(bcd_inc({3'b0, cur.mon}, 8'h12, 8'h01));
    if (c_mon)  nxt.year = bcd_inc(cur.year, 8'h99, 8'h00);
    if (c_year) nxt.cent = bcd_inc(cur.cent, 8'h99, 8'h00);
  end

  always_ff @(posedge clk) begin
    if (rst)         live_o <= RTC_RESET;
    else if (load_i) live_o <= load_val_i;   // commit wins; same-cycle tick dropped
    else             live_o <= nxt;
  end

endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_CENT = 1,
  parameter int unsigned OFS_CTRL = 8,
  parameter int unsigned OFS_SEC  = 9,
  parameter int unsigned OFS_MIN  = 10,
  parameter int unsigned OFS_HOUR = 11,
  parameter int unsigned OFS_DOW  = 12,
  parameter int unsigned OFS_DATE = 13,
  parameter int unsigned OFS_MON  = 14,
  parameter int unsigned OFS_YEAR = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         live_i,
  output rtc_time_t         shadow_o,
  output logic              frz_rd_o,
  output logic              frz_wr_o,
  output logic              commit_o
);

  logic ctrl_hit, resume_set, refresh, hold_q;

  assign ctrl_hit   = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign commit_o   = ctrl_hit && frz_wr_o && !wdata_i[7];
  assign resume_set = ctrl_hit && frz_rd_o && !frz_wr_o && (wdata_i[7:6] == 2'b00);
  assign refresh    = !frz_rd_o && !frz_wr_o && !hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_rd_o <= 1'b0;
      frz_wr_o <= 1'b0;
      hold_q   <= 1'b0;
      shadow_o <= RTC_RESET;
    end else begin
      if (ctrl_hit) begin
        frz_wr_o <= wdata_i[7];
        frz_rd_o <= wdata_i[6];
      end
      if (resume_set)  hold_q <= 1'b1;
      else if (tick_i) hold_q <= 1'b0;
      if (refresh) begin
        shadow_o <= live_i;
      end else if (frz_wr_o && wr_en_i) begin
        if (addr_i == ADDR_W'(OFS_SEC))  {shadow_o.stop, shadow_o.sec} <= wdata_i;
        if (addr_i == ADDR_W'(OFS_MIN))  shadow_o.min  <= wdata_i[6:0];
        if (addr_i == ADDR_W'(OFS_HOUR)) shadow_o.hour <= wdata_i[5:0];
        if (addr_i == ADDR_W'(OFS_DOW))  shadow_o.dow  <= wdata_i[2:0];
        if (addr_i == ADDR_W'(OFS_DATE)) shadow_o.date <= wdata_i[5:0];
        if (addr_i == ADDR_W'(OFS_MON))  shadow_o.mon  <= wdata_i[4:0];
        if (addr_i == ADDR_W'(OFS_YEAR)) shadow_o.year <= wdata_i;
        if (addr_i == ADDR_W'(OFS_CENT)) shadow_o.cent <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/rtc_rdmux.sv
module rtc_rdmux
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_CENT = 1,
  parameter int unsigned OFS_CTRL = 8,
  parameter int unsigned OFS_SEC  = 9,
  parameter int unsigned OFS_MIN  = 10,
  parameter int unsigned OFS_HOUR = 11,
  parameter int unsigned OFS_DOW  = 12,
  parameter int unsigned OFS_DATE = 13,
  parameter int unsigned OFS_MON  = 14,
  parameter int unsigned OFS_YEAR = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  rtc_time_t         shadow_i,
  input  logic              frz_rd_i,
  input  logic              frz_wr_i,
  output logic [7:0]        rdata_o
);

  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    if (addr_i == ADDR_W'(OFS_CTRL)) sel = {frz_wr_i, frz_rd_i, 6'b0};
    if (addr_i == ADDR_W'(OFS_SEC))  sel = {shadow_i.stop, shadow_i.sec};
    if (addr_i == ADDR_W'(OFS_MIN))  sel = {1'b0, shadow_i.min};
    if (addr_i == ADDR_W'(OFS_HOUR)) sel = {2'b0, shadow_i.hour};
    if (addr_i == ADDR_W'(OFS_DOW))  sel = {5'b0, shadow_i.dow};
    if (addr_i == ADDR_W'(OFS_DATE)) sel = {2'b0, shadow_i.date};
    if (addr_i == ADDR_W'(OFS_MON))  sel = {3'b0, shadow_i.mon};
    if (addr_i == ADDR_W'(OFS_YEAR)) sel = shadow_i.year;
    if (addr_i == ADDR_W'(OFS_CENT)) sel = shadow_i.cent;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= 8'h00;
    else     rdata_o <= sel;
  end

endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_CENT = 1,
  parameter int unsigned OFS_CTRL = 8,
  parameter int unsigned OFS_SEC  = 9,
  parameter int unsigned OFS_MIN  = 10,
  parameter int unsigned OFS_HOUR = 11,
  parameter int unsigned OFS_DOW  = 12,
  parameter int unsigned OFS_DATE = 13,
  parameter int unsigned OFS_MON  = 14,
  parameter int unsigned OFS_YEAR = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  rtc_time_t live, shadow;
  logic      commit, frz_rd, frz_wr;

  rtc_counter u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .load_i(commit), .load_val_i(shadow), .live_o(live)
  );

  rtc_regwin #(
    .ADDR_W(ADDR_W), .OFS_CENT(OFS_CENT), .OFS_CTRL(OFS_CTRL), .OFS_SEC(OFS_SEC),
    .OFS_MIN(OFS_MIN), .OFS_HOUR(OFS_HOUR), .OFS_DOW(OFS_DOW), .OFS_DATE(OFS_DATE),
    .OFS_MON(OFS_MON), .OFS_YEAR(OFS_YEAR)
  ) u_win (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .live_i(live), .shadow_o(shadow), .frz_rd_o(frz_rd),
    .frz_wr_o(frz_wr), .commit_o(commit)
  );

  rtc_rdmux #(
    .ADDR_W(ADDR_W), .OFS_CENT(OFS_CENT), .OFS_CTRL(OFS_CTRL), .OFS_SEC(OFS_SEC),
    .OFS_MIN(OFS_MIN), .OFS_HOUR(OFS_HOUR), .OFS_DOW(OFS_DOW), .OFS_DATE(OFS_DATE),
    .OFS_MON(OFS_MON), .OFS_YEAR(OFS_YEAR)
  ) u_rd (
    .clk(clk), .rst(rst), .addr_i(addr_i), .shadow_i(shadow),
    .frz_rd_i(frz_rd), .frz_wr_i(frz_wr), .rdata_o(rdata_o)
  );

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tick_i,
  input logic      commit,
  input rtc_time_t live,
  input rtc_time_t shadow,
  input logic      frz_rd,
  input logic      frz_wr
);

  p_count_runs_r1: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !commit && !live.stop) |=> (live != $past(live)));

  p_snapshot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (frz_rd && !frz_wr) |=> $stable(shadow));

  p_commit_load_r6: assert property (@(posedge clk) disable iff (rst)
    commit |=> (live == $past(shadow)));

  p_bcd_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (live.sec[3:0] <= 4'd9) && (live.sec[6:4] <= 3'd5) &&
    (live.min[3:0] <= 4'd9) && (live.min[6:4] <= 3'd5) &&
    (live.hour[3:0] <= 4'd9) && (live.hour <= 6'h23) &&
    (live.dow >= 3'd1) && (live.dow <= 3'd7) &&
    (live.date[3:0] <= 4'd9) && (live.date >= 6'h01) && (live.date <= 6'h31) &&
    (live.mon[3:0] <= 4'd9) && (live.mon >= 5'h01) && (live.mon <= 5'h12));

  p_ctrl_reset_r8: assert property (@(posedge clk)
    rst |=> (!frz_rd && !frz_wr));

  p_stop_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (live.stop && !commit) |=> $stable(live));

endmodule

bind rtc_shadow_top rtc_shadow_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .commit(commit), .live(live),
  .shadow(shadow), .frz_rd(frz_rd), .frz_wr(frz_wr)
);

// File: tb/rtc_shadow_top_bench.sv
`timescale 1ns/1ps
module rtc_shadow_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CENT = 4'h1, A_CTRL = 4'h8, A_SEC = 4'h9, A_MIN = 4'hA,
                         A_HOUR = 4'hB, A_DOW = 4'hC, A_DATE = 4'hD, A_MON = 4'hE,
                         A_YEAR = 4'hF;

  always #2 clk = ~clk;

  rtc_shadow_top u_rtc_shadow_top (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wr_with_tick(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a;
    @(negedge clk);
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y, c);
    wr_byte(A_CTRL, 8'h80);
    wr_byte(A_SEC, s);  wr_byte(A_MIN, mi); wr_byte(A_HOUR, h); wr_byte(A_DOW, dw);
    wr_byte(A_DATE, dt); wr_byte(A_MON, mo); wr_byte(A_YEAR, y); wr_byte(A_CENT, c);
    wr_byte(A_CTRL, 8'h00);
  endtask

  task automatic t_reset();
    rd_chk("R8 ctrl", A_CTRL, 8'h00);
    rd_chk("R8 sec", A_SEC, 8'h00);
    rd_chk("R8 dow", A_DOW, 8'h01);
    rd_chk("R8 date", A_DATE, 8'h01);
    rd_chk("R8 month", A_MON, 8'h01);
    rd_chk("R8 century", A_CENT, 8'h00);
    rd_chk("R10 unmapped", 4'h2, 8'h00);
  endtask

  task automatic t_rollover();
    wr_byte(A_CTRL, 8'h80);
    wr_byte(A_SEC, 8'h58); wr_byte(A_MIN, 8'h59); wr_byte(A_HOUR, 8'h23);
    wr_byte(A_DOW, 8'h07); wr_byte(A_DATE, 8'h31); wr_byte(A_MON, 8'h12);
    wr_byte(A_YEAR, 8'h99); wr_byte(A_CENT, 8'h19);
    rd_chk("R5 readback under write-freeze", A_SEC, 8'h58);
    wr_byte(A_CTRL, 8'h00);
    rd_chk("R6 committed sec", A_SEC, 8'h58);
    pulse_tick();
    rd_chk("R7 sec 59", A_SEC, 8'h59);
    pulse_tick();
    rd_chk("R7 sec wrap", A_SEC, 8'h00);
    rd_chk("R7 min wrap", A_MIN, 8'h00);
    rd_chk("R7 hour wrap", A_HOUR, 8'h00);
    rd_chk("R7 dow 7 to 1", A_DOW, 8'h01);
    rd_chk("R7 date wrap", A_DATE, 8'h01);
    rd_chk("R7 month wrap", A_MON, 8'h01);
    rd_chk("R7 year wrap", A_YEAR, 8'h00);
    rd_chk("R7 century carry", A_CENT, 8'h20);
  endtask

  task automatic t_ignored();
    wr_byte(A_SEC, 8'h33);
    rd_chk("R5 write ignored when running", A_SEC, 8'h00);
    wr_byte(A_CTRL, 8'h40);
    wr_byte(A_MIN, 8'h11);
    rd_chk("R5 write ignored under read-freeze", A_MIN, 8'h00);
    wr_byte(A_CTRL, 8'h00);
    pulse_tick();
  endtask

  task automatic t_month();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    pulse_tick();
    rd_chk("R7 Feb 28 non-leap date", A_DATE, 8'h01);
    rd_chk("R7 Feb 28 non-leap month", A_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    pulse_tick();
    rd_chk("R7 leap Feb 29", A_DATE, 8'h29);
    rd_chk("R7 leap month kept", A_MON, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24, 8'h20);
    pulse_tick();
    rd_chk("R7 Apr 30 date", A_DATE, 8'h01);
    rd_chk("R7 Apr 30 month", A_MON, 8'h05);
  endtask

  task automatic t_read_freeze();
    set_time(8'h10, 8'h05, 8'h12, 8'h02, 8'h15, 8'h06, 8'h30, 8'h20);
    wr_with_tick(A_CTRL, 8'h40);
    rd_chk("R3 snapshot excludes same-cycle tick", A_SEC, 8'h10);
    for (int i = 0; i < 3; i++) pulse_tick();
    rd_chk("R2 frozen across ticks", A_SEC, 8'h10);
    rd_chk("R2 ctrl shows read-freeze", A_CTRL, 8'h40);
    wr_byte(A_CTRL, 8'h00);
    rd_chk("R4 held until next tick", A_SEC, 8'h10);
    pulse_tick();
    rd_chk("R1 R4 counting continued", A_SEC, 8'h15);
  endtask

  task automatic t_commit_tick();
    wr_byte(A_CTRL, 8'h80);
    wr_byte(A_SEC, 8'h20);
    wr_with_tick(A_CTRL, 8'h00);
    rd_chk("R6 same-cycle tick dropped", A_SEC, 8'h20);
    pulse_tick();
    rd_chk("R6 next tick counts", A_SEC, 8'h21);
  endtask

  task automatic t_stop();
    wr_byte(A_CTRL, 8'h80);
    wr_byte(A_SEC, 8'h85);
    wr_byte(A_CTRL, 8'h00);
    pulse_tick();
    pulse_tick();
    rd_chk("R9 stopped sec", A_SEC, 8'h85);
    rd_chk("R9 stopped min", A_MIN, 8'h05);
    wr_byte(A_CTRL, 8'h80);
    wr_byte(A_SEC, 8'h05);
    wr_byte(A_CTRL, 8'h00);
    pulse_tick();
    rd_chk("R9 restarted", A_SEC, 8'h06);
  endtask

  task automatic t_map();
    wr_byte(A_CTRL, 8'hFF);
    rd_chk("R10 ctrl low bits zero", A_CTRL, 8'hC0);
    wr_byte(A_DOW, 8'hFF);
    rd_chk("R10 dow masked", A_DOW, 8'h07);
    wr_byte(A_HOUR, 8'hD2);
    rd_chk("R10 hour masked", A_HOUR, 8'h12);
    wr_byte(A_CTRL, 8'h00);
    rd_chk("R10 hour after commit", A_HOUR, 8'h12);
    rd_chk("R10 ctrl cleared", A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rollover();
    t_ignored();
    t_month();
    t_read_freeze();
    t_commit_tick();
    t_stop();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule